// File: doc/BRIEF.md
# Fault Ride-Through Power Reference Generator

This block supplies the active and reactive power set-points to a grid-forming control loop during a voltage sag. When the sag detector raises its flag, the block takes the sag depth, the reactive current flowing before the sag, the rated current and the d-axis grid voltage. It then works out a reactive current target that rises with sag depth, and it scales that target into a reactive power set-point. The active current is limited to whatever part of the current rating's circle is still free, and that limited current is scaled into an active power set-point. When the sag clears, the block loads the caller's normal set-points back onto its outputs.

The datapath is sequential and uses unsigned fixed point. Currents, voltages and the drop are Q8.8 (16 bits). The power outputs are Q16.8 (24 bits). The headroom current comes from a bit-serial integer square root that yields one result bit per clock. While a computation runs, the outputs keep their last values, and a one-cycle strobe marks each new pair of set-points. The controller has three states:
- IDLE waits.
- LOAD latches the inputs and starts the root.
- ROOT waits for the root to finish.

The transitions are:
- IDLE to LOAD on a fault flag.
- LOAD to ROOT unconditionally.
- ROOT to IDLE when the root is done.
- Any state to LOAD on a new fault flag.
- Any state to IDLE on a clear flag when no fault flag is present.

Top module: `frt_pref_gen`

## Requirements
- R1: After reset, `p_ref` and `q_ref` are 0, and `ref_valid` and `busy` are low.
- R2: The reactive demand is `iq_prefault + ((drop_pu * i_rate) >> 7)`, which is the pre-sag current plus twice the per-unit drop times rated current, with the Q8.8 product truncated. The demand is clamped to `i_rate` to give `iq_use`. `q_ref` is `(3 * ud_grid * iq_use) >> 9`, which is 1.5 × voltage × current in Q16.8, truncated.
- R3: The headroom current is `floor(sqrt(i_rate*i_rate - iq_use*iq_use))`, taken as an integer root of the Q16.16 difference and giving a Q8.8 result. `p_ref` is `(3 * ud_grid * headroom) >> 9`.
- R4: When the unclamped reactive demand is at or above `i_rate`, the new `p_ref` is 0 and `q_ref` uses `i_rate` as its current.
- R5: A `sag_clr` pulse without `sag_det` in the same cycle copies `p_nominal` and `q_nominal` to the outputs in the next cycle, with `ref_valid` high. It also abandons any computation in progress, so that computation produces no later strobe.
- R6: In the cycle after `sag_det` is sampled, `busy` is high. `busy` stays high until the result is posted. While no strobe is shown, `p_ref` and `q_ref` do not change.
- R7: Each new result is marked by `ref_valid` high for exactly one cycle, at most 20 cycles after `sag_det` is sampled, and with `busy` low.
- R8: A `sag_det` sampled while a computation is running restarts it with the newest inputs. Only one strobe follows, and it carries values computed from those newest inputs.
- R9: When `sag_det` and `sag_clr` are high in the same cycle, the fault wins: no restore strobe follows, and a computation starts.
- R10: A power result above 2^24-1 saturates at 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sag_det | input | 1 | Voltage sag detected; starts or restarts a computation |
| sag_clr | input | 1 | Sag cleared; restores the normal set-points |
| iq_prefault | input | 16 | Reactive current before the sag, Q8.8 |
| drop_pu | input | 16 | Voltage drop over nominal voltage, Q8.8 |
| i_rate | input | 16 | Rated current, Q8.8 |
| ud_grid | input | 16 | d-axis grid voltage, Q8.8 |
| p_nominal | input | 24 | Normal active power set-point, Q16.8 |
| q_nominal | input | 24 | Normal reactive power set-point, Q16.8 |
| p_ref | output | 24 | Active power set-point, Q16.8 |
| q_ref | output | 24 | Reactive power set-point, Q16.8 |
| ref_valid | output | 1 | One-cycle strobe marking new set-points |
| busy | output | 1 | A computation is in progress |

## Verification
The bench builds the block with its defaults: 16-bit Q8.8 operands, which give a 32-bit radicand, a 16-step root and 24-bit power outputs. With these widths, full-scale operands overflow the 1.5 × product, so the saturation path can be reached. A drop and rated current of modest size move the demand across the rating, so both sides of the headroom clamp can be exercised. Because the root takes 16 cycles, a second fault flag can be placed well inside the computation window, and so can a clear flag.

// File: rtl/frt_pkg.sv
package frt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_ROOT = 2'd2
    } frt_state_t;
endpackage

// File: rtl/frt_iq_calc.sv
// Reactive demand, clamp against the rating, and the radicand for the headroom root.
module frt_iq_calc #(
    parameter int W    = 16,
    parameter int FRAC = 8
) (
    input  logic [W-1:0]   iq_pre,
    input  logic [W-1:0]   drop,
    input  logic [W-1:0]   irate,
    output logic [W-1:0]   iq_use,
    output logic           at_limit,
    output logic [2*W-1:0] radicand
);
    localparam int DW = 2 * W + 2;

    logic [2*W-1:0] slope_prod;
    logic [DW-1:0]  demand;
    logic [2*W-1:0] ir_sq;
    logic [2*W-1:0] iq_sq;

    always_comb begin
        slope_prod = irate * drop;
        // twice the Q8.8 product: shift by one bit less than the fraction width
        demand     = DW'(iq_pre) + DW'(slope_prod >> (FRAC - 1));
        at_limit   = (demand >= DW'(irate));
        iq_use     = at_limit ? irate : W'(demand);
        ir_sq      = irate * irate;
        iq_sq      = iq_use * iq_use;
        radicand   = ir_sq - iq_sq;
    end
endmodule

// File: rtl/frt_isqrt.sv
// Bit-serial restoring square root, one result bit per cycle.
module frt_isqrt #(
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] radicand,
    output logic [RW/2-1:0] root,
    output logic          busy
);
    localparam int QW   = RW / 2;
    localparam int REMW = QW + 3;
    localparam int CW   = $clog2(QW + 1);

    logic [RW-1:0]   rad_sh;
    logic [REMW-1:0] rem;
    logic [CW-1:0]   cnt;
    logic [REMW-1:0] rem_t;
    logic [REMW-1:0] trial;
    logic [REMW-1:0] rem_nx;
    logic [QW-1:0]   root_nx;

    always_comb begin
        rem_t = REMW'({rem, rad_sh[RW-1:RW-2]});
        trial = REMW'({root, 2'b01});
        if (rem_t >= trial) begin
            rem_nx  = rem_t - trial;
            root_nx = {root[QW-2:0], 1'b1};
        end else begin
            rem_nx  = rem_t;
            root_nx = {root[QW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rad_sh <= '0;
            rem    <= '0;
            root   <= '0;
            cnt    <= '0;
            busy   <= 1'b0;
        end else if (start) begin
            rad_sh <= radicand;
            rem    <= '0;
            root   <= '0;
            cnt    <= CW'(QW);
            busy   <= 1'b1;
        end else if (busy) begin
            rad_sh <= rad_sh << 2;
            rem    <= rem_nx;
            root   <= root_nx;
            cnt    <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/frt_pow_scale.sv
// 1.5 x voltage x current, Q8.8 operands to a saturated Q16.8 power.
module frt_pow_scale #(
    parameter int W    = 16,
    parameter int FRAC = 8,
    parameter int PW   = 24
) (
    input  logic [W-1:0]  volt,
    input  logic [W-1:0]  cur,
    output logic [PW-1:0] pwr
);
    localparam int XW = 2 * W + 2;
    localparam logic [XW-1:0] PMAX = {{(XW - PW){1'b0}}, {PW{1'b1}}};

    logic [XW-1:0] prod3;
    logic [XW-1:0] scaled;

    always_comb begin
        prod3  = XW'(volt) * XW'(cur) * XW'(3);
        scaled = prod3 >> (FRAC + 1);
        pwr    = (scaled > PMAX) ? {PW{1'b1}} : scaled[PW-1:0];
    end
endmodule

// File: rtl/frt_pref_gen.sv
module frt_pref_gen #(
    parameter int W    = 16,
    parameter int FRAC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sag_det,
    input  logic              sag_clr,
    input  logic [W-1:0]      iq_prefault,
    input  logic [W-1:0]      drop_pu,
    input  logic [W-1:0]      i_rate,
    input  logic [W-1:0]      ud_grid,
    input  logic [W+FRAC-1:0] p_nominal,
    input  logic [W+FRAC-1:0] q_nominal,
    output logic [W+FRAC-1:0] p_ref,
    output logic [W+FRAC-1:0] q_ref,
    output logic              ref_valid,
    output logic              busy
);
    import frt_pkg::*;

    localparam int PW = W + FRAC;
    localparam int RW = 2 * W;

    frt_state_t state, state_nx;

    logic [W-1:0]  iq_pre_q, drop_q, irate_q, ud_q;
    logic [W-1:0]  iq_use;
    logic          lim;
    logic [RW-1:0] radicand;
    logic [W-1:0]  id_root;
    logic          sq_busy;
    logic          sq_start;
    logic          finish;

    logic [W-1:0]  cur_sel [2];
    logic [PW-1:0] pwr_sel [2];

    frt_iq_calc #(.W(W), .FRAC(FRAC)) u_iq (
        .iq_pre   (iq_pre_q),
        .drop     (drop_q),
        .irate    (irate_q),
        .iq_use   (iq_use),
        .at_limit (lim),
        .radicand (radicand)
    );

    frt_isqrt #(.RW(RW)) u_root (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sq_start),
        .radicand (radicand),
        .root     (id_root),
        .busy     (sq_busy)
    );

    assign cur_sel[0] = id_root;   // active path
    assign cur_sel[1] = iq_use;    // reactive path

    for (genvar g = 0; g < 2; g++) begin : g_pow
        frt_pow_scale #(.W(W), .FRAC(FRAC), .PW(PW)) u_pow (
            .volt (ud_q),
            .cur  (cur_sel[g]),
            .pwr  (pwr_sel[g])
        );
    end

    assign sq_start = (state == ST_LOAD);
    assign finish   = (state == ST_ROOT) && !sq_busy;
    assign busy     = (state != ST_IDLE);

    // next state
    always_comb begin
        state_nx = state;
        if (sag_det) begin
            state_nx = ST_LOAD;
        end else if (sag_clr) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_LOAD: state_nx = ST_ROOT;
                ST_ROOT: state_nx = sq_busy ? ST_ROOT : ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // input capture on each fault flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iq_pre_q <= '0;
            drop_q   <= '0;
            irate_q  <= '0;
            ud_q     <= '0;
        end else if (sag_det) begin
            iq_pre_q <= iq_prefault;
            drop_q   <= drop_pu;
            irate_q  <= i_rate;
            ud_q     <= ud_grid;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_ref     <= '0;
            q_ref     <= '0;
            ref_valid <= 1'b0;
        end else begin
            ref_valid <= 1'b0;
            if (sag_det) begin
                ref_valid <= 1'b0;
            end else if (sag_clr) begin
                p_ref     <= p_nominal;
                q_ref     <= q_nominal;
                ref_valid <= 1'b1;
            end else if (finish) begin
                p_ref     <= lim ? '0 : pwr_sel[0];
                q_ref     <= pwr_sel[1];
                ref_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/frt_pref_gen_chk.sv
module frt_pref_gen_chk #(
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sag_det,
    input logic          sag_clr,
    input logic [PW-1:0] p_nominal,
    input logic [PW-1:0] q_nominal,
    input logic [PW-1:0] p_ref,
    input logic [PW-1:0] q_ref,
    input logic          ref_valid,
    input logic          busy,
    input logic          lim
);
    a_r5_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_clr && !sag_det) |=> (ref_valid && !busy &&
            p_ref == $past(p_nominal) && q_ref == $past(q_nominal)));

    a_r6_fault_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sag_det |=> (busy && !ref_valid));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |-> ($stable(p_ref) && $stable(q_ref)));

    a_r7_idle_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> !busy);

    a_r7_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> ($past(busy) || $past(sag_clr)));

    a_r4_limit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !$past(sag_clr) && lim) |-> (p_ref == '0));
endmodule

bind frt_pref_gen frt_pref_gen_chk #(.PW(W + FRAC)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sag_det   (sag_det),
    .sag_clr   (sag_clr),
    .p_nominal (p_nominal),
    .q_nominal (q_nominal),
    .p_ref     (p_ref),
    .q_ref     (q_ref),
    .ref_valid (ref_valid),
    .busy      (busy),
    .lim       (lim)
);

// File: tb/test_frt_pref_gen.sv
module test_frt_pref_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sag_det = 1'b0;
    logic        sag_clr = 1'b0;
    logic [15:0] iq_prefault = '0;
    logic [15:0] drop_pu = '0;
    logic [15:0] i_rate = '0;
    logic [15:0] ud_grid = '0;
    logic [23:0] p_nominal = '0;
    logic [23:0] q_nominal = '0;
    logic [23:0] p_ref;
    logic [23:0] q_ref;
    logic        ref_valid;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    frt_pref_gen i_frt_pref_gen (
        .clk(clk), .rst_n(rst_n), .sag_det(sag_det), .sag_clr(sag_clr),
        .iq_prefault(iq_prefault), .drop_pu(drop_pu), .i_rate(i_rate),
        .ud_grid(ud_grid), .p_nominal(p_nominal), .q_nominal(q_nominal),
        .p_ref(p_ref), .q_ref(q_ref), .ref_valid(ref_valid), .busy(busy)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic longint root_ref(input longint x);
        longint r = 0;
        for (int b = 15; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= x) r = t;
        end
        return r;
    endfunction

    function automatic longint pw_ref(input longint u, input longint i);
        longint v = (3 * u * i) >> 9;
        return (v > 64'hFFFFFF) ? 64'hFFFFFF : v;
    endfunction

    function automatic void exp_pq(input longint iqp, input longint dr, input longint ir,
                                   input longint ud, output longint ep, output longint eq);
        longint dem = iqp + ((dr * ir) >> 7);
        longint iq  = (dem >= ir) ? ir : dem;
        eq = pw_ref(ud, iq);
        ep = (dem >= ir) ? 0 : pw_ref(ud, root_ref(ir * ir - iq * iq));
    endfunction

    task automatic set_in(input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] c, input logic [15:0] d);
        iq_prefault = a; drop_pu = b; i_rate = c; ud_grid = d;
    endtask

    // pulse fault, then wait for the strobe while watching the held outputs
    task automatic run_sag(input string req, input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] c, input logic [15:0] d);
        longint ep, eq;
        logic [23:0] hp, hq;
        int lat = 0;
        exp_pq(a, b, c, d, ep, eq);
        @(negedge clk);
        set_in(a, b, c, d);
        sag_det = 1'b1;
        hp = p_ref; hq = q_ref;
        @(negedge clk);
        sag_det = 1'b0;
        set_in(16'h0, 16'h0, 16'h0, 16'h0);
        lat = 1;
        check({req, " R6 busy after fault"}, busy, 1);
        while (!ref_valid && lat < 40) begin
            if (p_ref != hp || q_ref != hq) check({req, " R6 hold"}, p_ref, hp);
            @(negedge clk);
            lat++;
        end
        check({req, " R7 strobe within 20"}, (lat <= 20), 1);
        check({req, " R7 busy low on strobe"}, busy, 0);
        check({req, " R3 p_ref"}, p_ref, ep);
        check({req, " R2 q_ref"}, q_ref, eq);
        @(negedge clk);
        check({req, " R7 one-cycle strobe"}, ref_valid, 0);
    endtask

    task automatic t_reset;
        check("R1 p_ref", p_ref, 0);
        check("R1 q_ref", q_ref, 0);
        check("R1 ref_valid", ref_valid, 0);
        check("R1 busy", busy, 0);
    endtask

    task automatic t_clear;
        @(negedge clk);
        p_nominal = 24'h00C800; q_nominal = 24'h000123;
        sag_clr = 1'b1;
        @(negedge clk);
        sag_clr = 1'b0;
        check("R5 valid", ref_valid, 1);
        check("R5 p restore", p_ref, 24'h00C800);
        check("R5 q restore", q_ref, 24'h000123);
        @(negedge clk);
        check("R5 strobe ends", ref_valid, 0);
    endtask

    task automatic t_clear_abort;
        int seen = 0;
        @(negedge clk);
        set_in(16'h0000, 16'h0066, 16'h0100, 16'h0100);
        sag_det = 1'b1;
        @(negedge clk);
        sag_det = 1'b0;
        repeat (5) @(negedge clk);
        p_nominal = 24'h000777; q_nominal = 24'h000888;
        sag_clr = 1'b1;
        @(negedge clk);
        sag_clr = 1'b0;
        check("R5 abort p", p_ref, 24'h000777);
        check("R5 abort q", q_ref, 24'h000888);
        check("R5 abort busy", busy, 0);
        repeat (30) begin
            @(negedge clk);
            if (ref_valid) seen++;
        end
        check("R5 no late strobe", seen, 0);
    endtask

    task automatic t_restart;
        longint ep, eq;
        int seen = 0;
        exp_pq(16'h0040, 16'h0033, 16'h0180, 16'h00E0, ep, eq);
        @(negedge clk);
        set_in(16'h0000, 16'h0066, 16'h0100, 16'h0100);
        sag_det = 1'b1;
        @(negedge clk);
        sag_det = 1'b0;
        repeat (7) @(negedge clk);
        set_in(16'h0040, 16'h0033, 16'h0180, 16'h00E0);
        sag_det = 1'b1;
        @(negedge clk);
        sag_det = 1'b0;
        repeat (40) begin
            if (ref_valid) begin
                seen++;
                check("R8 restart p", p_ref, ep);
                check("R8 restart q", q_ref, eq);
            end
            @(negedge clk);
        end
        check("R8 single strobe", seen, 1);
    endtask

    task automatic t_both;
        longint ep, eq;
        int seen = 0;
        exp_pq(16'h0020, 16'h0080, 16'h0100, 16'h0100, ep, eq);
        @(negedge clk);
        set_in(16'h0020, 16'h0080, 16'h0100, 16'h0100);
        p_nominal = 24'h0ABCDE; q_nominal = 24'h0ABCDE;
        sag_det = 1'b1; sag_clr = 1'b1;
        @(negedge clk);
        sag_det = 1'b0; sag_clr = 1'b0;
        check("R9 no restore strobe", ref_valid, 0);
        check("R9 busy", busy, 1);
        repeat (40) begin
            if (ref_valid) begin
                seen++;
                check("R9 fault wins p", p_ref, ep);
                check("R9 fault wins q", q_ref, eq);
            end
            @(negedge clk);
        end
        check("R9 one strobe", seen, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_sag("R2 sag 0.4 pu", 16'h0000, 16'h0066, 16'h0100, 16'h0100);
        run_sag("R3 shallow sag", 16'h0030, 16'h0010, 16'h0140, 16'h00F0);
        run_sag("R3 zero drop", 16'h0000, 16'h0000, 16'h0100, 16'h0100);
        run_sag("R4 deep sag", 16'h0040, 16'h0099, 16'h0100, 16'h0066);
        run_sag("R4 exact limit", 16'h0080, 16'h0040, 16'h0100, 16'h0100);
        run_sag("R10 sat P", 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF);
        run_sag("R10 sat Q", 16'h0000, 16'h0100, 16'hFFFF, 16'hFFFF);
        t_clear();
        t_clear_abort();
        t_restart();
        t_both();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule